// File: doc/BRIEF.md
# Dual-Channel Successive-Approximation Conversion Sequencer

This block is the digital control half of a two-channel 12-bit successive-approximation converter that measures a sine and a cosine signal together. A single start pulse opens a sampling interval. The block then runs a binary search on both channels in lockstep from one sequencer. On every step it drives a trial code per channel to an external DAC and reads one comparator bit per channel back.

The trial codes are the result outputs. Each trial code stays constant long enough for the comparators to settle. When the last bit is resolved, one completion flag covers both channels, and both codes hold their final values until the next start. The pins here are plain control and status strobes, not a data stream, so no valid/ready handshake applies. The start pin is a request that the block takes only while idle, and the completion flag is a level that stays up until the next accepted start.

Top module: `dual_sar_ctrl`

## Requirements
- R1: One accepted start converts the sine and the cosine channel together, and a single completion flag `conv_done` reports both results.
- R2: `sampling` goes high in the cycle after `start` is accepted and stays high for exactly SAMPLE_CLKS (default 128) clocks.
- R3: Every trial code on `sin_code` and `cos_code` stays constant for at least SETTLE_CLKS (default 128) clocks before it changes.
- R4: The search begins at the MSB. When `sampling` falls both codes read 0x800. At the end of each hold the bit under trial is kept when that channel's comparator input is 1 (input above the DAC level) and cleared when it is 0, and the next lower bit is then trialled as 1.
- R5: `conv_done` is cleared on the clock edge that accepts a start, is low while a conversion runs, and stays high from the end of a conversion until the next accepted start.
- R6: With an ideal comparator that reports 1 when the input is at or above the trial code, each final code equals that channel's 12-bit unsigned input. This holds over the full range 0x000 to 0xFFF.
- R7: `conv_done` rises SAMPLE_CLKS + 12 × SETTLE_CLKS clocks (1664 by default) after the edge that accepts the start.
- R8: After reset `conv_done` and `sampling` are low and both codes read 0x000.
- R9: A `start` pulse that arrives while a conversion runs has no effect on the codes, the timing or the results.
- R10: An accepted start clears both codes to 0x000, and they read zero for the whole sampling interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, accepted only while idle |
| cmp_sin | input | 1 | Sine comparator, 1 = input above trial level |
| cmp_cos | input | 1 | Cosine comparator, 1 = input above trial level |
| sin_code | output | 12 | Sine trial code to the DAC, final result when done |
| cos_code | output | 12 | Cosine trial code to the DAC, final result when done |
| sampling | output | 1 | High during the sample interval |
| conv_done | output | 1 | Set when both results are final, cleared on start |

## Verification
The assertions assume that reset is applied first and that the comparator inputs are only sampled at the end of each hold, so any value on them is legal. They also assume a start accepted while idle is the only event that clears the codes, which is why the hold-time property is excused on the cycle in which `sampling` rises. The bench models an ideal comparator as a combinational compare of a held analog value against the current trial code. It changes the analog values only while the block is idle, so every comparator decision sees a settled input.

// File: rtl/dual_sar_pkg.sv
package dual_sar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_TRIAL  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dual_sar_timer.sv
module dual_sar_timer #(
  parameter int unsigned MAX_LEN = 128,
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + 1'b1;
  end
endmodule

// File: rtl/dual_sar_search_reg.sv
module dual_sar_search_reg #(
  parameter int unsigned W = 12,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_msb,
  input  logic             decide,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output logic [W-1:0]     code
);
  logic [W-1:0] code_nxt;

  always_comb begin
    code_nxt = code;
    if (clear) begin
      code_nxt = '0;
    end else if (load_msb) begin
      code_nxt[W-1] = 1'b1;
    end else if (decide) begin
      code_nxt[bit_idx] = cmp;
      if (bit_idx != '0) code_nxt[bit_idx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= code_nxt;
  end
endmodule

// File: rtl/dual_sar_sequencer.sv
module dual_sar_sequencer
  import dual_sar_pkg::*;
#(
  parameter int unsigned W           = 12,
  parameter int unsigned SAMPLE_CLKS = 128,
  parameter int unsigned SETTLE_CLKS = 128,
  localparam int unsigned IDX_W   = $clog2(W),
  localparam int unsigned MAX_LEN = (SAMPLE_CLKS > SETTLE_CLKS) ? SAMPLE_CLKS : SETTLE_CLKS,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             timer_clr,
  output logic             clear,
  output logic             load_msb,
  output logic             decide,
  output logic [IDX_W-1:0] bit_idx,
  output logic             sampling,
  output logic             done
);
  localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(W - 1);
  localparam logic [CNT_W-1:0] SAMPLE_END = CNT_W'(SAMPLE_CLKS - 1);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CLKS - 1);

  seq_state_t state;
  logic       term;

  always_comb begin
    term = 1'b0;
    case (state)
      SEQ_SAMPLE: term = (count == SAMPLE_END);
      SEQ_TRIAL:  term = (count == SETTLE_END);
      default:    term = 1'b0;
    endcase
  end

  assign timer_clr = (state == SEQ_IDLE) || term;
  assign clear     = (state == SEQ_IDLE) && start;
  assign load_msb  = (state == SEQ_SAMPLE) && term;
  assign decide    = (state == SEQ_TRIAL) && term;
  assign sampling  = (state == SEQ_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      bit_idx <= TOP_IDX;
      done    <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_SAMPLE;
          done  <= 1'b0;
        end
        SEQ_SAMPLE: if (term) begin
          state   <= SEQ_TRIAL;
          bit_idx <= TOP_IDX;
        end
        SEQ_TRIAL: if (term) begin
          if (bit_idx == '0) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_sar_ctrl.sv
module dual_sar_ctrl #(
  parameter int unsigned W           = 12,
  parameter int unsigned SAMPLE_CLKS = 128,
  parameter int unsigned SETTLE_CLKS = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_sin,
  input  logic         cmp_cos,
  output logic [W-1:0] sin_code,
  output logic [W-1:0] cos_code,
  output logic         sampling,
  output logic         conv_done
);
  localparam int unsigned IDX_W   = $clog2(W);
  localparam int unsigned MAX_LEN = (SAMPLE_CLKS > SETTLE_CLKS) ? SAMPLE_CLKS : SETTLE_CLKS;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned NCH     = 2;

  logic [CNT_W-1:0] count;
  logic             timer_clr, clear, load_msb, decide;
  logic [IDX_W-1:0] bit_idx;
  logic [NCH-1:0]   cmp_vec;
  logic [W-1:0]     codes [NCH];

  assign cmp_vec = {cmp_cos, cmp_sin};

  dual_sar_timer #(.MAX_LEN(MAX_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .count(count)
  );

  dual_sar_sequencer #(
    .W(W), .SAMPLE_CLKS(SAMPLE_CLKS), .SETTLE_CLKS(SETTLE_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .timer_clr(timer_clr), .clear(clear), .load_msb(load_msb),
    .decide(decide), .bit_idx(bit_idx), .sampling(sampling), .done(conv_done)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dual_sar_search_reg #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .clear(clear), .load_msb(load_msb),
      .decide(decide), .bit_idx(bit_idx), .cmp(cmp_vec[ch]), .code(codes[ch])
    );
  end

  assign sin_code = codes[0];
  assign cos_code = codes[1];
endmodule

// File: rtl/dual_sar_ctrl_chk.sv
module dual_sar_ctrl_chk #(
  parameter int unsigned W           = 12,
  parameter int unsigned SETTLE_CLKS = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] sin_code,
  input logic [W-1:0] cos_code,
  input logic         sampling,
  input logic         conv_done
);
  localparam int unsigned HW = $clog2(SETTLE_CLKS + 2);
  localparam logic [W-1:0] MSB_CODE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  prev_sin, prev_cos;
  logic [HW-1:0] held;
  logic          changed;

  assign changed = (sin_code != prev_sin) || (cos_code != prev_cos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sin <= '0;
      prev_cos <= '0;
      held     <= HW'(SETTLE_CLKS);
    end else begin
      prev_sin <= sin_code;
      prev_cos <= cos_code;
      if (changed)                      held <= HW'(1);
      else if (held < HW'(SETTLE_CLKS)) held <= held + 1'b1;
    end
  end

  assert_smpl_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sampling) |-> $past(start));

  assert_trial_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (changed && !$rose(sampling)) |-> (held >= HW'(SETTLE_CLKS)));

  assert_first_trial_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sampling) |-> (sin_code == MSB_CODE && cos_code == MSB_CODE));

  assert_done_low_in_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> !conv_done);

  assert_done_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !start) |=> conv_done);

  assert_codes_zero_in_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> (sin_code == '0 && cos_code == '0));
endmodule

bind dual_sar_ctrl dual_sar_ctrl_chk #(.W(W), .SETTLE_CLKS(SETTLE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sin_code(sin_code),
  .cos_code(cos_code), .sampling(sampling), .conv_done(conv_done)
);

// File: tb/dual_sar_ctrl_test.sv
module dual_sar_ctrl_test;
  localparam int W = 12;
  localparam int SAMPLE_CLKS = 128;
  localparam int SETTLE_CLKS = 128;
  localparam int LAT = SAMPLE_CLKS + W * SETTLE_CLKS + 1;
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h000FFF, 24'hFFF000, 24'h8007FF, 24'h7FF800,
    24'h123ABC, 24'h555AAA, 24'h001FFE, 24'h9C43E8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] ana_sin = '0, ana_cos = '0;
  logic [W-1:0] sin_code, cos_code;
  logic sampling, conv_done;
  logic cmp_sin, cmp_cos;

  int checks = 0;
  int errors = 0;

  int lat, smpl_cnt, first_sin, first_cos, done_after_start;
  bit nonzero_in_sample;

  always #5 clk = ~clk;

  assign cmp_sin = (ana_sin >= sin_code);
  assign cmp_cos = (ana_cos >= cos_code);

  dual_sar_ctrl #(.W(W), .SAMPLE_CLKS(SAMPLE_CLKS), .SETTLE_CLKS(SETTLE_CLKS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_sin(cmp_sin), .cmp_cos(cmp_cos),
    .sin_code(sin_code), .cos_code(cos_code), .sampling(sampling), .conv_done(conv_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [W-1:0] s, input logic [W-1:0] c, input int inject_at);
    logic prev_smpl;
    @(negedge clk);
    ana_sin = s;
    ana_cos = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_after_start = conv_done;
    lat = 1;
    smpl_cnt = sampling ? 1 : 0;
    nonzero_in_sample = sampling && (sin_code != 0 || cos_code != 0);
    first_sin = -1;
    first_cos = -1;
    prev_smpl = sampling;
    while (!conv_done && lat < 3 * LAT) begin
      @(negedge clk);
      lat++;
      start = (lat == inject_at);
      if (sampling) smpl_cnt++;
      if (sampling && (sin_code != 0 || cos_code != 0)) nonzero_in_sample = 1'b1;
      if (prev_smpl && !sampling) begin
        first_sin = sin_code;
        first_cos = cos_code;
      end
      prev_smpl = sampling;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(sin_code == 0 && cos_code == 0, "R8 codes after reset", sin_code, 0);
    chk(!conv_done && !sampling, "R8 flags after reset", {conv_done, sampling}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R6, R7: table of analog inputs walked by one loop
    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC[i][23:12], VEC[i][11:0], 0);
      chk(sin_code == VEC[i][23:12], "R6 sine result", sin_code, VEC[i][23:12]);
      chk(cos_code == VEC[i][11:0], "R1 cosine result", cos_code, VEC[i][11:0]);
      chk(lat == LAT, "R7 conversion latency", lat, LAT);
    end

    // R2, R4, R10: sampling window and first trial code
    run_conv(12'h3C3, 12'hC3C, 0);
    chk(smpl_cnt == SAMPLE_CLKS, "R2 sampling length", smpl_cnt, SAMPLE_CLKS);
    chk(!nonzero_in_sample, "R10 codes zero while sampling", nonzero_in_sample, 0);
    chk(first_sin == 'h800 && first_cos == 'h800, "R4 first trial MSB", first_sin, 'h800);
    // R5: flag cleared at accepted start (previous conversion left it high)
    chk(done_after_start == 0, "R5 done cleared on start", done_after_start, 0);
    chk(conv_done == 1, "R5 done set at end", conv_done, 1);

    // R9: start pulses mid-sample and mid-search are ignored
    run_conv(12'hA5A, 12'h5A5, 60);
    chk(lat == LAT, "R9 latency with start in sample", lat, LAT);
    chk(sin_code == 12'hA5A && cos_code == 12'h5A5, "R9 result with start in sample", sin_code, 12'hA5A);
    run_conv(12'h0F0, 12'hF0F, 900);
    chk(lat == LAT, "R9 latency with start in search", lat, LAT);
    chk(sin_code == 12'h0F0 && cos_code == 12'hF0F, "R9 result with start in search", cos_code, 12'hF0F);

    // R5: done holds while idle with no start
    repeat (300) @(negedge clk);
    chk(conv_done == 1 && sin_code == 12'h0F0, "R5 done held while idle", conv_done, 1);

    // R3: trial hold checked by code sampling at mid-hold and end-of-hold
    begin
      logic [W-1:0] mid;
      run_conv(12'h000, 12'h000, 0);
      @(negedge clk);
      ana_sin = 12'hFFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (SAMPLE_CLKS + 1) @(negedge clk);
      mid = sin_code;
      repeat (SETTLE_CLKS - 2) @(negedge clk);
      chk(sin_code == mid && mid == 12'h800, "R3 trial held", sin_code, mid);
      @(negedge clk);
      chk(sin_code == 12'hC00, "R3 next trial after hold", sin_code, 12'hC00);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule